// File: doc/BRIEF.md
# Serial Test Access Port with Identification and Boundary Chain

This block is the serial test port of a memory device. It contains the sixteen-state test controller and a 3-bit instruction register. Three data registers sit behind it: a single-bit bypass stage, a 32-bit identification word, and a boundary chain of parameterised length.

The controller samples TMS and TDI on the rising edge of the test clock. TDO changes on the falling edge. Every register shifts from its most significant end toward TDO, so the least significant bit leaves first. The boundary chain takes a snapshot of a parallel pin-image bus. It can also load a parallel update bus, which the surrounding pad logic uses.

One instruction asks the pads to go to high impedance. The block raises a request output for it and leaves the pads to the user. Holding TMS high returns the port to its reset state, and doing so leaves the memory core untouched.

Top module: `scan_tap`

## Requirements
- R1: While `trst_n` is low, `tdo_oe` is 0, `hiz_req` is 0 and `pin_update` is all zeros. The current instruction is also IDCODE, so a data scan that follows returns the identification word.
- R2: TDI and TMS are sampled on the rising edge of `tck`, and `tdo` changes only on the falling edge. `tdo_oe` is 1 exactly while the controller sits in Shift-IR or Shift-DR.
- R3: Capture-IR loads the instruction shift stages with binary 001 (bit 0 = 1, bits 2:1 = 0), and TDO presents them LSB first. A shifted instruction becomes current only on the rising edge that leaves Update-IR.
- R4: The instruction codes are 000 EXTEST, 001 IDCODE, 010 SAMPLE-Z, 100 SAMPLE/PRELOAD and 111 BYPASS. The codes 011, 101 and 110 select the bypass stage.
- R5: Under a bypass-selecting code, Capture-DR clears the bypass stage to 0. In Shift-DR, TDO then follows TDI delayed by one clock.
- R6: Under IDCODE, Capture-DR loads the following fixed word:
  - revision in bits 31:28
  - depth code in bits 27:23
  - width code in bits 22:18
  - device number in bits 17:12
  - 11-bit manufacturer code in bits 11:1
  - a 1 in bit 0
- R7: Under 000, 010 or 100, Capture-DR loads `pin_capture` into the boundary chain of `BSR_LEN` stages. Shift-DR then moves it out LSB first while TDI enters at the MSB.
- R8: `pin_update` loads the boundary chain only on the rising edge that leaves Update-DR, and only under a boundary instruction. Under any other instruction it holds its value.
- R9: `hiz_req` is 1 exactly while the current instruction is SAMPLE-Z (010).
- R10: Five consecutive rising edges with TMS high bring the controller to Test-Logic-Reset from any state. The current instruction returns to IDCODE and `tdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low port reset (power-on) |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_oe | output | 1 | Drive enable for `tdo`; 0 means high impedance |
| pin_capture | input | BSR_LEN | Parallel pin image captured into the boundary chain |
| pin_update | output | BSR_LEN | Boundary update latch toward the pads |
| hiz_req | output | 1 | Request to float the device pins |

## Verification
The bench sweeps all eight instruction codes. Under each code it performs a 40-bit data scan with a code-dependent TDI pattern and pin image. The shape of what comes back tells the three data registers apart: output delayed by one with a leading 0 means bypass, the fixed identification word followed by TDI means IDCODE, and the pin image means boundary. A following check of `pin_update` shows whether the update latch moved. All 256 eight-step TMS walks, each followed by five TMS-high edges, show that every reachable state returns to reset and restores IDCODE. A scan interrupted at Exit1-IR and Update-IR separates the instruction shift stages from the current instruction.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

   typedef enum logic [3:0] {
      TS_RESET, TS_IDLE,
      TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
      TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
   } tap_state_e;

   localparam int unsigned IR_W = 3;
   typedef logic [IR_W-1:0] instr_t;

   localparam instr_t OP_EXTEST  = 3'b000;
   localparam instr_t OP_IDCODE  = 3'b001;
   localparam instr_t OP_SAMPLEZ = 3'b010;
   localparam instr_t OP_SAMPLE  = 3'b100;
   localparam instr_t OP_BYPASS  = 3'b111;
   localparam instr_t IR_CAPTURE = 3'b001;

   typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_BSR} dr_sel_e;

   function automatic dr_sel_e dr_decode(instr_t op);
      dr_sel_e s;
      case (op)
         OP_IDCODE:                         s = SEL_ID;
         OP_EXTEST, OP_SAMPLEZ, OP_SAMPLE:  s = SEL_BSR;
         default:                           s = SEL_BYP;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
   import scan_tap_pkg::*;
(
   input  logic       tck,
   input  logic       rst_n,
   input  logic       tms,
   output tap_state_e state
);

   tap_state_e nxt;

   always_comb begin
      case (state)
         TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
         TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
         TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
         TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SHF_DR;
         TS_SHF_DR: nxt = tms ? TS_EX1_DR : TS_SHF_DR;
         TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
         TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
         TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SHF_DR;
         TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
         TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
         TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SHF_IR;
         TS_SHF_IR: nxt = tms ? TS_EX1_IR : TS_SHF_IR;
         TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
         TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
         TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SHF_IR;
         TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_IDLE;
         default:   nxt = TS_RESET;
      endcase
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) state <= TS_RESET;
      else        state <= nxt;
   end

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
   import scan_tap_pkg::*;
(
   input  logic       tck,
   input  logic       rst_n,
   input  tap_state_e state,
   input  logic       tdi,
   output logic       ir_lsb,
   output instr_t     ir_cur
);

   instr_t ir_sr;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         ir_sr  <= OP_IDCODE;
         ir_cur <= OP_IDCODE;
      end else begin
         if (state == TS_CAP_IR)      ir_sr <= IR_CAPTURE;
         else if (state == TS_SHF_IR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};

         if (state == TS_RESET)       ir_cur <= OP_IDCODE;
         else if (state == TS_UPD_IR) ir_cur <= ir_sr;
      end
   end

   assign ir_lsb = ir_sr[0];

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
   import scan_tap_pkg::*;
#(
   parameter int unsigned BSR_LEN  = 75,
   parameter int unsigned ID_W     = 32,
   parameter logic [ID_W-1:0] ID_VALUE = '0
) (
   input  logic               tck,
   input  logic               rst_n,
   input  tap_state_e         state,
   input  dr_sel_e            sel,
   input  logic               tdi,
   input  logic [BSR_LEN-1:0] pin_capture,
   output logic               byp_q,
   output logic               id_lsb,
   output logic               bsr_lsb,
   output logic [BSR_LEN-1:0] pin_update
);

   logic            cap_en, shf_en, upd_en;
   logic [ID_W-1:0] id_sr;
   logic [BSR_LEN-1:0] bsr_sr;

   assign cap_en = (state == TS_CAP_DR);
   assign shf_en = (state == TS_SHF_DR);
   assign upd_en = (state == TS_UPD_DR) && (sel == SEL_BSR);

   // single-stage bypass path
   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) byp_q <= 1'b0;
      else if (sel == SEL_BYP) begin
         if (cap_en)      byp_q <= 1'b0;
         else if (shf_en) byp_q <= tdi;
      end
   end

   // identification word
   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) id_sr <= ID_VALUE;
      else if (sel == SEL_ID) begin
         if (cap_en)      id_sr <= ID_VALUE;
         else if (shf_en) id_sr <= {tdi, id_sr[ID_W-1:1]};
      end
   end

   // boundary chain: one capture/shift stage and one update latch per pin
   for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
      logic shin, sh_q, up_q;
      if (i == BSR_LEN-1) begin : g_head
         assign shin = tdi;
      end else begin : g_body
         assign shin = bsr_sr[i+1];
      end

      always_ff @(posedge tck or negedge rst_n) begin
         if (!rst_n) sh_q <= 1'b0;
         else if (sel == SEL_BSR) begin
            if (cap_en)      sh_q <= pin_capture[i];
            else if (shf_en) sh_q <= shin;
         end
      end

      always_ff @(posedge tck or negedge rst_n) begin
         if (!rst_n)      up_q <= 1'b0;
         else if (upd_en) up_q <= sh_q;
      end

      assign bsr_sr[i]     = sh_q;
      assign pin_update[i] = up_q;
   end

   assign id_lsb  = id_sr[0];
   assign bsr_lsb = bsr_sr[0];

endmodule

// File: rtl/scan_tap.sv
module scan_tap
   import scan_tap_pkg::*;
#(
   parameter int unsigned BSR_LEN    = 75,
   parameter bit          HAS_TRST   = 1'b1,
   parameter logic [3:0]  REVISION   = 4'h0,
   parameter logic [4:0]  DEPTH_CODE = 5'b00111,
   parameter logic [4:0]  WIDTH_CODE = 5'b00100,
   parameter logic [5:0]  DEVICE_NUM = 6'h00,
   parameter logic [10:0] MFR_CODE   = 11'h0D5
) (
   input  logic               tck,
   input  logic               trst_n,
   input  logic               tms,
   input  logic               tdi,
   output logic               tdo,
   output logic               tdo_oe,
   input  logic [BSR_LEN-1:0] pin_capture,
   output logic [BSR_LEN-1:0] pin_update,
   output logic               hiz_req
);

   localparam int unsigned ID_W = 32;
   localparam logic [ID_W-1:0] ID_VALUE =
      {REVISION, DEPTH_CODE, WIDTH_CODE, DEVICE_NUM, MFR_CODE, 1'b1};

   if (BSR_LEN < 2 || BSR_LEN > 4096) begin : g_bad_len
      $error("scan_tap: BSR_LEN must lie in 2..4096");
   end
   if (MFR_CODE == 11'h07F) begin : g_bad_mfr
      $error("scan_tap: manufacturer code 0x7F is reserved");
   end

   logic rst_n;
   if (HAS_TRST) begin : g_trst
      assign rst_n = trst_n;
   end else begin : g_no_trst
      assign rst_n = 1'b1;
   end

   tap_state_e state;
   instr_t     ir_cur;
   dr_sel_e    sel;
   logic       ir_lsb, byp_q, id_lsb, bsr_lsb;
   logic       tdo_nxt, oe_nxt;

   scan_tap_fsm u_fsm (
      .tck   (tck),
      .rst_n (rst_n),
      .tms   (tms),
      .state (state)
   );

   scan_tap_ir u_ir (
      .tck    (tck),
      .rst_n  (rst_n),
      .state  (state),
      .tdi    (tdi),
      .ir_lsb (ir_lsb),
      .ir_cur (ir_cur)
   );

   assign sel = dr_decode(ir_cur);

   scan_tap_dr #(
      .BSR_LEN  (BSR_LEN),
      .ID_W     (ID_W),
      .ID_VALUE (ID_VALUE)
   ) u_dr (
      .tck         (tck),
      .rst_n       (rst_n),
      .state       (state),
      .sel         (sel),
      .tdi         (tdi),
      .pin_capture (pin_capture),
      .byp_q       (byp_q),
      .id_lsb      (id_lsb),
      .bsr_lsb     (bsr_lsb),
      .pin_update  (pin_update)
   );

   always_comb begin
      oe_nxt = (state == TS_SHF_IR) || (state == TS_SHF_DR);
      if (state == TS_SHF_IR) tdo_nxt = ir_lsb;
      else begin
         case (sel)
            SEL_ID:  tdo_nxt = id_lsb;
            SEL_BSR: tdo_nxt = bsr_lsb;
            default: tdo_nxt = byp_q;
         endcase
      end
   end

   // output stage retimed to the falling edge
   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n) begin
         tdo    <= 1'b0;
         tdo_oe <= 1'b0;
      end else begin
         tdo    <= tdo_nxt;
         tdo_oe <= oe_nxt;
      end
   end

   assign hiz_req = (ir_cur == OP_SAMPLEZ);

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
   import scan_tap_pkg::*;
#(
   parameter int unsigned BSR_LEN = 75
) (
   input logic               tck,
   input logic               rst_n,
   input logic               tms,
   input tap_state_e         state,
   input instr_t             ir_cur,
   input logic               byp_q,
   input logic [BSR_LEN-1:0] pin_update,
   input logic               tdo_oe
);

   logic [2:0] ones_cnt;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)             ones_cnt <= '0;
      else if (!tms)          ones_cnt <= '0;
      else if (ones_cnt != 7) ones_cnt <= ones_cnt + 3'd1;
   end

   AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!rst_n)
      (ones_cnt >= 3'd5) |-> (state == TS_RESET)); // R10

   AST_OE_SHIFT_ONLY: assert property (@(posedge tck) disable iff (!rst_n)
      tdo_oe == ((state == TS_SHF_IR) || (state == TS_SHF_DR))); // R2

   AST_IR_CHANGE_POINT: assert property (@(posedge tck) disable iff (!rst_n)
      !$stable(ir_cur) |-> ($past(state) == TS_UPD_IR || $past(state) == TS_RESET)); // R3

   AST_RESET_IDCODE: assert property (@(posedge tck) disable iff (!rst_n)
      (state == TS_RESET) |=> (ir_cur == OP_IDCODE)); // R10

   AST_BYPASS_ZERO: assert property (@(posedge tck) disable iff (!rst_n)
      (state == TS_CAP_DR && dr_decode(ir_cur) == SEL_BYP) |=> (byp_q == 1'b0)); // R5

   AST_UPDATE_POINT: assert property (@(posedge tck) disable iff (!rst_n)
      !$stable(pin_update) |-> ($past(state) == TS_UPD_DR)); // R8

endmodule

bind scan_tap scan_tap_chk #(.BSR_LEN(BSR_LEN)) u_chk (
   .tck        (tck),
   .rst_n      (rst_n),
   .tms        (tms),
   .state      (state),
   .ir_cur     (ir_cur),
   .byp_q      (byp_q),
   .pin_update (pin_update),
   .tdo_oe     (tdo_oe)
);

// File: tb/scan_tap_bench.sv
`timescale 1ns/1ps
module scan_tap_bench;

   localparam int unsigned LEN = 75;
   localparam logic [31:0] EXP_ID = {4'h0, 5'b00111, 5'b00100, 6'h00, 11'h0D5, 1'b1};

   logic           tck = 1'b0;
   logic           trst_n = 1'b0;
   logic           tms = 1'b1;
   logic           tdi = 1'b0;
   logic           tdo, tdo_oe, hiz_req;
   logic [LEN-1:0] pin_capture = '0;
   logic [LEN-1:0] pin_update;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #4 tck = ~tck;

   scan_tap #(.BSR_LEN(LEN)) u_scan_tap (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
      .pin_capture(pin_capture), .pin_update(pin_update), .hiz_req(hiz_req)
   );

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive one rising edge; o returns TDO as seen at that edge
   task automatic step(input logic m, input logic d, output logic o);
      o = tdo; tms = m; tdi = d;
      @(posedge tck); @(negedge tck); #1;
   endtask

   task automatic ir_scan(input logic [2:0] code, output logic [2:0] q);
      logic o;
      step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
      for (int i = 0; i < 3; i++) begin step(i == 2, code[i], o); q[i] = o; end
      step(1, 0, o); step(0, 0, o);
   endtask

   task automatic dr_scan(input int n, input logic [127:0] din, output logic [127:0] q);
      logic o;
      q = '0;
      step(1, 0, o); step(0, 0, o); step(0, 0, o);
      for (int i = 0; i < n; i++) begin step(i == n-1, din[i], o); q[i] = o; end
      step(1, 0, o); step(0, 0, o);
   endtask

   initial begin
      repeat (200000) @(posedge tck);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic o;
      logic [2:0] q3;
      logic [127:0] q, din, e;
      logic [LEN-1:0] prev_upd, e_upd;
      logic a, b;

      #20;
      chk("R1 oe", tdo_oe, 0);
      chk("R1 hiz", hiz_req, 0);
      chk("R1 update", pin_update, 0);
      @(negedge tck); #1; trst_n = 1'b1;
      step(0, 0, o);
      chk("R2 oe idle", tdo_oe, 0);

      dr_scan(32, '0, q);
      chk("R6 R1 idcode", q[31:0], EXP_ID);

      ir_scan(3'b111, q3);
      chk("R3 capture 001", q3, 3'b001);

      din = 128'h5A;
      dr_scan(8, din, q);
      chk("R5 bypass delay", q[7:0], {din[6:0], 1'b0});

      // R2: enable in shift, tdo steady across a rising edge
      step(1, 0, o); step(0, 0, o); step(0, 0, o);
      chk("R2 oe shift", tdo_oe, 1);
      a = tdo; tms = 0; tdi = ~tdo;
      @(posedge tck); #1; b = tdo;
      chk("R2 tdo on falling", b, a);
      @(negedge tck); #1;
      step(1, 0, o); step(1, 0, o); step(0, 0, o);
      chk("R2 oe after", tdo_oe, 0);

      // R3: instruction takes effect only leaving Update-IR
      step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
      step(0, 0, o); step(0, 1, o); step(1, 0, o);
      chk("R3 exit1 no effect", hiz_req, 0);
      step(1, 0, o);
      chk("R3 update no effect yet", hiz_req, 0);
      step(0, 0, o);
      chk("R9 samplez active", hiz_req, 1);

      // R4 R7 R8 R9: sweep all instruction codes
      for (int c = 0; c < 8; c++) begin
         pin_capture = {3{32'h7F4A_7C15 ^ (32'(c) * 32'h0101_0101)}};
         din = {4{32'h9E37_79B9 * 32'(c + 1)}};
         prev_upd = pin_update;
         ir_scan(3'(c), q3);
         chk("R9 hiz per code", hiz_req, (c == 2));
         dr_scan(40, din, q);
         e = '0;
         if (c == 0 || c == 2 || c == 4) begin
            for (int i = 0; i < 40; i++) e[i] = pin_capture[i];
            for (int j = 0; j < LEN; j++)
               e_upd[j] = (j >= LEN-40) ? din[j-(LEN-40)] : pin_capture[j+40];
         end else if (c == 1) begin
            for (int i = 0; i < 40; i++) e[i] = (i < 32) ? EXP_ID[i] : din[i-32];
            e_upd = prev_upd;
         end else begin
            for (int i = 1; i < 40; i++) e[i] = din[i-1];
            e_upd = prev_upd;
         end
         chk($sformatf("R4 R7 scan code %0d", c), q[39:0], e[39:0]);
         chk($sformatf("R8 update code %0d", c), pin_update, e_upd);
      end

      // R1: asynchronous reset mid-run spanning two edges
      ir_scan(3'b010, q3);
      chk("R9 before reset", hiz_req, 1);
      trst_n = 0;
      @(posedge tck); @(posedge tck); #1;
      chk("R1 hiz async", hiz_req, 0);
      chk("R1 oe async", tdo_oe, 0);
      chk("R1 update async", pin_update, 0);
      @(negedge tck); #1; trst_n = 1;
      step(0, 0, o);

      // R10: every 8-step TMS walk, then five ones
      for (int p = 0; p < 256; p++) begin
         ir_scan(3'b111, q3);
         for (int k = 0; k < 8; k++) step(p[k], 0, o);
         for (int k = 0; k < 5; k++) step(1, 0, o);
         chk("R10 oe in reset", tdo_oe, 0);
         step(0, 0, o);
         dr_scan(32, '0, q);
         chk($sformatf("R10 idcode after walk %0d", p), q[31:0], EXP_ID);
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule